// File: doc/BRIEF.md
# Two-Phase Power-Register Unsigned Divider

This block divides one unsigned integer by another over several clock cycles and returns both the quotient and the remainder from a single operation. A caller presents a dividend and a divisor with a one-cycle `start_i` strobe while the block is idle. The block raises `busy_o` while it works, then pulses `done_o` for one cycle with the results on `quot_o` and `rem_o`. The results stay on those outputs until the next operation completes.

Internally the block runs in two phases. In the first phase it scales the divisor up. The divisor and a one-hot weight register shift left together until the scaled divisor is larger than the dividend. In the second phase it walks back down. On each step, if the scaled divisor fits into the remaining dividend, the block subtracts it and merges the weight into the quotient. Both registers then shift right, and the operation ends when the weight has shifted out. The number of cycles therefore depends on the operands. A zero divisor skips both phases: the block raises a flag and returns fixed values on the next cycle.

Top module: `powdiv_top`

## Requirements
- R1: While reset is high and on the cycle after it, `busy_o`, `done_o` and `div_zero_o` are 0, and `quot_o` and `rem_o` are 0.
- R2: A `start_i` sampled while `busy_o` is 0 with a nonzero divisor makes `busy_o` 1 on the next cycle. While busy, the internal weight register has exactly one bit set.
- R3: Let k be the smallest integer with divisor·2^k greater than the dividend. `done_o` is 1 exactly 2k+2 clock edges after the edge that accepted the start, and `busy_o` is 1 in every cycle in between.
- R4: In the reduction phase the working remainder is always less than twice the scaled divisor, and each reduction step shifts the weight right by one bit.
- R5: When `done_o` is 1 after a nonzero divisor, `quot_o` equals floor(dividend/divisor) and `rem_o` equals dividend mod divisor.
- R6: `done_o` is high for one cycle. It rises in the same cycle that `busy_o` falls, and after a nonzero divisor `div_zero_o` is 0 in that cycle.
- R7: A start accepted with divisor 0 gives, on the next cycle, `done_o`=1, `div_zero_o`=1, `quot_o` all ones and `rem_o` equal to the dividend. `busy_o` stays 0.
- R8: When the dividend is less than the divisor, the result is quotient 0 with the remainder equal to the dividend, and `done_o` follows the start after 2 edges.
- R9: `start_i` is ignored while `busy_o` is 1. The running operation's results and timing are unaffected, and no second operation follows.
- R10: `quot_o`, `rem_o` and `div_zero_o` change only in a cycle where `done_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted only when not busy |
| dividend_i | input | W | Unsigned dividend, sampled with an accepted start |
| divisor_i | input | W | Unsigned divisor, sampled with an accepted start |
| busy_o | output | 1 | High while an operation is running |
| done_o | output | 1 | One-cycle completion pulse |
| quot_o | output | W | Quotient of the last completed operation |
| rem_o | output | W | Remainder of the last completed operation |
| div_zero_o | output | 1 | High when the last completed operation had a zero divisor |

## Verification
Every cycle, the assertions check the following. The weight register stays one-hot while busy. During reduction the remainder stays below twice the scaled divisor and the weight shifts right one bit per step. The move from alignment to reduction happens once the divisor has passed the dividend. The zero-divisor response arrives the cycle after the start. The results change only together with `done_o`. Only the bench's scenarios can show that the quotient and remainder are numerically correct. The same holds for the data-dependent latency of 2k+2 edges and for starts being ignored while busy. The bench checks both at the extremes: no alignment shifts, and the maximum of W shifts with a divisor of 1.

// File: rtl/powdiv_pkg.sv
package powdiv_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ALIGN  = 2'd1,
    PH_REDUCE = 2'd2
  } phase_t;
endpackage

// File: rtl/powdiv_ctrl.sv
module powdiv_ctrl
  import powdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start_i,
  input  logic   dvs_zero_i,
  input  logic   fits_i,
  input  logic   last_i,
  output phase_t phase_o,
  output logic   load_o,
  output logic   zero_fin_o,
  output logic   shift_up_o,
  output logic   step_down_o,
  output logic   finish_o
);
  phase_t phase_q, phase_d;

  always_comb begin
    phase_d     = phase_q;
    load_o      = 1'b0;
    zero_fin_o  = 1'b0;
    shift_up_o  = 1'b0;
    step_down_o = 1'b0;
    finish_o    = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          if (dvs_zero_i) begin
            zero_fin_o = 1'b1;
          end else begin
            load_o  = 1'b1;
            phase_d = PH_ALIGN;
          end
        end
      end
      PH_ALIGN: begin
        if (fits_i) shift_up_o = 1'b1;
        else        phase_d    = PH_REDUCE;
      end
      PH_REDUCE: begin
        step_down_o = 1'b1;
        if (last_i) begin
          finish_o = 1'b1;
          phase_d  = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  // R3: alignment ends once the divisor has passed the dividend
  assert_align_exit_R3: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_ALIGN && !fits_i) |=> (phase_q == PH_REDUCE));

endmodule

// File: rtl/powdiv_dpath.sv
module powdiv_dpath
  import powdiv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  phase_t       phase_i,
  input  logic         load_i,
  input  logic         shift_up_i,
  input  logic         step_down_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         fits_o,
  output logic         last_o,
  output logic [W-1:0] quot_step_o,
  output logic [W-1:0] rem_step_o
);
  localparam int WD = W + 1;

  logic [WD-1:0] dvs_q;
  logic [WD-1:0] pow_q;
  logic [W-1:0]  rem_q;
  logic [W-1:0]  quot_q;

  assign fits_o = (dvs_q <= {1'b0, rem_q});
  assign last_o = (pow_q == WD'(1));

  always_comb begin
    quot_step_o = quot_q;
    rem_step_o  = rem_q;
    if (fits_o) begin
      quot_step_o = quot_q | pow_q[W-1:0];
      rem_step_o  = rem_q - dvs_q[W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dvs_q  <= '0;
      pow_q  <= '0;
      rem_q  <= '0;
      quot_q <= '0;
    end else if (load_i) begin
      dvs_q  <= {1'b0, divisor_i};
      pow_q  <= WD'(1);
      rem_q  <= dividend_i;
      quot_q <= '0;
    end else if (shift_up_i) begin
      dvs_q <= dvs_q << 1;
      pow_q <= pow_q << 1;
    end else if (step_down_i) begin
      quot_q <= quot_step_o;
      rem_q  <= rem_step_o;
      dvs_q  <= dvs_q >> 1;
      pow_q  <= pow_q >> 1;
    end
  end

  // R2: weight stays one-hot while an operation runs
  assert_pow_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    (phase_i != PH_IDLE) |-> ($countones(pow_q) == 1));

  // R4: remainder below twice the scaled divisor during reduction
  assert_rem_bound_R4: assert property (@(posedge clk) disable iff (rst)
    (phase_i == PH_REDUCE) |-> ({2'b00, rem_q} < {dvs_q, 1'b0}));

  // R4: each non-final reduction step halves the weight
  assert_pow_halves_R4: assert property (@(posedge clk) disable iff (rst)
    (phase_i == PH_REDUCE && !last_o) |=> (pow_q == ($past(pow_q) >> 1)));

endmodule

// File: rtl/powdiv_top.sv
module powdiv_top
  import powdiv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o,
  output logic         div_zero_o
);
  phase_t       phase;
  logic         load, zero_fin, shift_up, step_down, finish;
  logic         fits, last;
  logic [W-1:0] quot_step, rem_step;

  powdiv_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .dvs_zero_i  (divisor_i == '0),
    .fits_i      (fits),
    .last_i      (last),
    .phase_o     (phase),
    .load_o      (load),
    .zero_fin_o  (zero_fin),
    .shift_up_o  (shift_up),
    .step_down_o (step_down),
    .finish_o    (finish)
  );

  powdiv_dpath #(.W(W)) u_dpath (
    .clk         (clk),
    .rst         (rst),
    .phase_i     (phase),
    .load_i      (load),
    .shift_up_i  (shift_up),
    .step_down_i (step_down),
    .dividend_i  (dividend_i),
    .divisor_i   (divisor_i),
    .fits_o      (fits),
    .last_o      (last),
    .quot_step_o (quot_step),
    .rem_step_o  (rem_step)
  );

  assign busy_o = (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o     <= 1'b0;
      quot_o     <= '0;
      rem_o      <= '0;
      div_zero_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (finish) begin
        done_o     <= 1'b1;
        quot_o     <= quot_step;
        rem_o      <= rem_step;
        div_zero_o <= 1'b0;
      end else if (zero_fin) begin
        done_o     <= 1'b1;
        quot_o     <= '1;
        rem_o      <= dividend_i;
        div_zero_o <= 1'b1;
      end
    end
  end

  // R7: zero divisor answered on the next cycle with fixed values
  assert_zero_div_R7: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && divisor_i == '0) |=>
      (done_o && div_zero_o && !busy_o && quot_o == '1 && rem_o == $past(dividend_i)));

  // R6: busy falls exactly with the completion pulse
  assert_done_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (done_o && !div_zero_o));

  // R6: done never overlaps a running operation
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R10: results only move together with done
  assert_hold_results_R10: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(quot_o) && $stable(rem_o) && $stable(div_zero_o)));

endmodule

// File: tb/test_powdiv_top.sv
`timescale 1ns/1ps
module test_powdiv_top;
  localparam int W = 8;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [W-1:0] dividend_i = '0;
  logic [W-1:0] divisor_i = '0;
  logic         busy_o, done_o, div_zero_o;
  logic [W-1:0] quot_o, rem_o;

  always #2.5 clk = ~clk;

  powdiv_top #(.W(W)) i_powdiv_top (
    .clk(clk), .rst(rst), .start_i(start_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .busy_o(busy_o), .done_o(done_o), .quot_o(quot_o),
    .rem_o(rem_o), .div_zero_o(div_zero_o)
  );

  int    n_checks = 0;
  int    n_fail = 0;
  string cur_tag = "R5";
  bit    compare_on = 1'b0;

  // behavioural reference state
  bit m_busy = 0, m_done = 0, m_dz = 0;
  int m_q = 0, m_r = 0, m_cnt = 0, p_q = 0, p_r = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int shifts_for(input int a, input int b);
    int k = 0;
    while ((b << k) <= a) k++;
    return k;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_dz = 0; m_q = 0; m_r = 0; m_cnt = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1; m_q = p_q; m_r = p_r; m_dz = 0;
        end
      end else if (start_i) begin
        if (divisor_i == 0) begin
          m_done = 1; m_dz = 1; m_q = MAXV; m_r = int'(dividend_i);
        end else begin
          m_busy = 1;
          m_cnt  = 2 * shifts_for(int'(dividend_i), int'(divisor_i)) + 2;
          p_q    = int'(dividend_i) / int'(divisor_i);
          p_r    = int'(dividend_i) % int'(divisor_i);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (compare_on) begin
      chk(busy_o == m_busy, "R3", "busy", int'(busy_o), int'(m_busy));
      chk(done_o == m_done, "R6", "done", int'(done_o), int'(m_done));
      // R4 reduction correctness shows up in these values
      chk(int'(quot_o) == m_q, m_done ? cur_tag : "R10", "quotient", int'(quot_o), m_q);
      chk(int'(rem_o) == m_r, m_done ? cur_tag : "R10", "remainder", int'(rem_o), m_r);
      chk(div_zero_o == m_dz, m_done ? cur_tag : "R10", "div_zero", int'(div_zero_o), int'(m_dz));
    end
  end

  task automatic run_div(input int a, input int b, input string tag, input bit hammer);
    cur_tag = tag;
    @(negedge clk);
    start_i = 1'b1; dividend_i = W'(a); divisor_i = W'(b);
    @(negedge clk);
    if (b != 0) chk(busy_o == 1'b1, "R2", "busy after start", int'(busy_o), 1);
    if (hammer) begin
      // R9: keep requesting with other operands while busy
      while (busy_o) begin
        dividend_i = W'($urandom_range(0, MAXV));
        divisor_i  = W'($urandom_range(0, MAXV));
        @(negedge clk);
      end
    end
    start_i = 1'b0;
    while (busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  bit finished = 0;

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy_o == 0 && done_o == 0 && div_zero_o == 0, "R1", "flags in reset",
        int'({busy_o, done_o, div_zero_o}), 0);
    chk(quot_o == 0 && rem_o == 0, "R1", "results in reset", int'({quot_o, rem_o}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy_o == 0 && done_o == 0, "R1", "idle after reset", int'({busy_o, done_o}), 0);
    compare_on = 1'b1;

    run_div(94, 7, "R5", 0);     // four alignment shifts
    run_div(255, 1, "R5", 0);    // maximum alignment
    run_div(255, 255, "R5", 0);
    run_div(128, 3, "R5", 0);
    run_div(5, 9, "R8", 0);      // no alignment shift
    run_div(0, 5, "R8", 0);
    run_div(200, 0, "R7", 0);    // zero divisor
    run_div(0, 0, "R7", 0);
    run_div(77, 0, "R7", 0);
    run_div(93, 4, "R9", 1);     // start held high while busy
    run_div(250, 1, "R9", 1);
    run_div(10, 3, "R5", 0);
    for (int i = 0; i < 300; i++) begin
      run_div($urandom_range(0, MAXV), $urandom_range(0, MAXV), "R5", i % 7 == 0);
    end

    compare_on = 1'b0;
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule